// File: doc/BRIEF.md
# Digital CDR Phase-Rotation Loop

This block closes the digital part of a clock and data recovery loop. On every clock it takes four lanes of early/late phase-detector decisions, one lane per unit interval of a 1:4 deserialized stream, and reduces them to a signed net vote. Two paths act on that vote. A proportional path shifts it by a programmable gain. An integrating path adds a scaled copy to a signed frequency register. The integer part of that register is added to the proportional term to give a requested rotation. The request is clamped to at most two phase steps per cycle and then accumulated into a 5-bit receive interpolator code. The code has 32 steps per unit interval and wraps.

A second interpolator code for the transmitter is derived from the same per-cycle rotation. A shift-based first-order low-pass smooths the rotation, and its fractional output is accumulated into a transmit phase whose integer part is the transmit code. With the smoothing shift at zero, the transmit code follows the receive code exactly. Larger shifts let the transmitter follow the recovered clock while filtering out phase jitter. A freeze input holds all loop state. A synchronous reset clears it.

Top module: `cdr_phase_rotator`

## Requirements
- R1: While `rst` is high at a rising edge, `rx_code`, `tx_code`, `freq_word` and the smoothing state all become zero.
- R2: Lane i votes +1 when `early[i]`=1 and `late[i]`=0, and votes −1 when `late[i]`=1 and `early[i]`=0. It votes 0 when both bits are equal. The net vote is the sum of the four lane votes, in the range −4..+4.
- R3: The proportional term is the net vote shifted arithmetically right by `kp_shift` (0..3), rounding toward minus infinity.
- R4: The applied step is proportional term plus integer part of the frequency register, clamped to −2..+2.
- R5: `rx_code` becomes (`rx_code` + step) mod 32 one clock after the votes are presented.
- R6: `freq_word` is a signed value with 8 fractional bits. Each unfrozen cycle it adds (net × 256) shifted arithmetically right by `ki_shift` (0..7). A zero net vote leaves it unchanged.
- R7: `freq_word` saturates at +512 and −512 (±2.0 steps per cycle) instead of wrapping.
- R8: The integer part of `freq_word` used in R4 is `freq_word` shifted arithmetically right by 8, so −64 contributes −1. The step uses the register value from before the current update.
- R9: With `tx_shift`=0 the smoothed rotation equals the applied step, and `tx_code` equals `rx_code` on every cycle.
- R10: The smoother state y (8 fractional bits) updates as y += (step×256 − y) >>> `tx_shift`. A 13-bit transmit phase adds the new y each cycle, and `tx_code` is its top 5 bits.
- R11: While `freeze` is high, `rx_code`, `tx_code`, `freq_word` and the smoother state hold, whatever the votes are.
- R12: `tx_code` wraps modulo 32 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock, one cycle per four unit intervals |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Holds all loop state while high |
| early | input | 4 | Per-lane early decisions |
| late | input | 4 | Per-lane late decisions |
| kp_shift | input | 2 | Proportional right-shift |
| ki_shift | input | 3 | Integral right-shift |
| tx_shift | input | 3 | Transmit smoothing shift |
| rx_code | output | 5 | Receive interpolator code |
| tx_code | output | 5 | Transmit interpolator code |
| freq_word | output | 12 | Signed frequency register, 8 fractional bits |

## Verification
A corrupted frequency register shows first on `freq_word`, in the same cycle. One cycle later it appears as a steady drift in `rx_code` whenever its integer part is nonzero, even with idle votes. A wrong vote reduction or clamp changes `rx_code` one clock after the offending vote pattern. Smoother faults appear on `tx_code` at once when `tx_shift` is zero, because it must match `rx_code`. With larger shifts they appear over several cycles as a divergence from the expected fractional phase.

// File: rtl/cdr_rot_pkg.sv
package cdr_rot_pkg;
    localparam int VOTE_LANES     = 4;
    localparam int PI_CODE_W      = 5;
    localparam int STEP_LIMIT     = 2;
    localparam int FREQ_FRAC_BITS = 8;
    localparam int TX_FRAC_BITS   = 8;

    // one lane decision: +1 early, -1 late, 0 for no or ambiguous transition
    function automatic logic signed [1:0] lane_vote(input logic e, input logic l);
        case ({e, l})
            2'b10:   return 2'sb01;
            2'b01:   return 2'sb11;
            default: return 2'sb00;
        endcase
    endfunction
endpackage

// File: rtl/cdr_vote_sum.sv
module cdr_vote_sum import cdr_rot_pkg::*; #(
    parameter int LANES = VOTE_LANES,
    parameter int NET_W = $clog2(LANES + 1) + 1
) (
    input  logic [LANES-1:0]        early_i,
    input  logic [LANES-1:0]        late_i,
    output logic signed [NET_W-1:0] net_o
);
    logic signed [1:0] vote [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign vote[g] = lane_vote(early_i[g], late_i[g]);
    end

    always_comb begin
        logic signed [NET_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            acc = acc + NET_W'(vote[i]);
        end
        net_o = acc;
    end
endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter #(
    parameter int NET_W     = 4,
    parameter int STEP_W    = 3,
    parameter int MAX_STEP  = 2,
    parameter int FREQ_FRAC = 8,
    parameter int FREQ_W    = FREQ_FRAC + STEP_W + 1,
    parameter int KP_W      = 2,
    parameter int KI_W      = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hold_i,
    input  logic signed [NET_W-1:0]  net_i,
    input  logic [KP_W-1:0]          kp_i,
    input  logic [KI_W-1:0]          ki_i,
    output logic signed [STEP_W-1:0] step_o,
    output logic signed [FREQ_W-1:0] freq_o
);
    localparam int SUM_W = FREQ_W + 2;
    localparam int F_LIM = MAX_STEP * (2 ** FREQ_FRAC);

    typedef struct packed {
        logic signed [FREQ_W-1:0] freq;
    } lf_state_t;

    lf_state_t st_d, st_q;
    logic signed [SUM_W-1:0] net_x, prop, fint, req, inc, fsum, fnext;

    always_comb begin
        st_d  = st_q;
        net_x = SUM_W'(net_i);
        prop  = net_x >>> kp_i;
        fint  = SUM_W'(st_q.freq) >>> FREQ_FRAC;
        req   = prop + fint;
        if (req > SUM_W'(MAX_STEP)) begin
            step_o = STEP_W'(MAX_STEP);
        end else if (req < SUM_W'(-MAX_STEP)) begin
            step_o = STEP_W'(-MAX_STEP);
        end else begin
            step_o = STEP_W'(req);
        end
        inc  = (net_x <<< FREQ_FRAC) >>> ki_i;
        fsum = SUM_W'(st_q.freq) + inc;
        if (fsum > SUM_W'(F_LIM)) begin
            fnext = SUM_W'(F_LIM);
        end else if (fsum < SUM_W'(-F_LIM)) begin
            fnext = SUM_W'(-F_LIM);
        end else begin
            fnext = fsum;
        end
        if (!hold_i) begin
            st_d.freq = FREQ_W'(fnext);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_o = st_q.freq;

    // R6: an idle vote word leaves the frequency register untouched
    assert_idle_freq_R6: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && net_i == '0) |=> $stable(st_q.freq));

    // R7: the frequency register never leaves its saturation window
    assert_freq_window_R7: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && $signed(st_q.freq) == FREQ_W'(F_LIM) && net_i > 0)
            |=> ($signed(st_q.freq) == FREQ_W'(F_LIM)));
endmodule

// File: rtl/cdr_tx_smoother.sv
module cdr_tx_smoother #(
    parameter int STEP_W  = 3,
    parameter int CODE_W  = 5,
    parameter int TX_FRAC = 8,
    parameter int K_W     = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hold_i,
    input  logic signed [STEP_W-1:0] step_i,
    input  logic [K_W-1:0]           k_i,
    output logic [CODE_W-1:0]        code_o
);
    localparam int Y_W = TX_FRAC + STEP_W + 1;
    localparam int D_W = Y_W + 1;
    localparam int P_W = CODE_W + TX_FRAC;

    typedef struct packed {
        logic signed [Y_W-1:0] y;
        logic [P_W-1:0]        phase;
    } sm_state_t;

    sm_state_t st_d, st_q;
    logic signed [D_W-1:0] x_s, diff, adj, y_new;

    always_comb begin
        st_d  = st_q;
        x_s   = D_W'(step_i) <<< TX_FRAC;
        diff  = x_s - D_W'(st_q.y);
        adj   = diff >>> k_i;
        y_new = D_W'(st_q.y) + adj;
        if (!hold_i) begin
            st_d.y     = Y_W'(y_new);
            st_d.phase = st_q.phase + P_W'(st_d.y);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.phase[P_W-1 -: CODE_W];

    // R9: with no smoothing the filter output is a whole number of steps
    assert_unsmoothed_whole_R9: assert property (@(posedge clk) disable iff (rst)
        (k_i == '0 && !hold_i) |=> (st_q.y[TX_FRAC-1:0] == '0));
endmodule

// File: rtl/cdr_phase_rotator.sv
module cdr_phase_rotator import cdr_rot_pkg::*; #(
    parameter int LANES     = VOTE_LANES,
    parameter int CODE_W    = PI_CODE_W,
    parameter int MAX_STEP  = STEP_LIMIT,
    parameter int FREQ_FRAC = FREQ_FRAC_BITS,
    parameter int TX_FRAC   = TX_FRAC_BITS,
    parameter int KP_W      = 2,
    parameter int KI_W      = 3,
    parameter int K_W       = 3,
    localparam int NET_W    = $clog2(LANES + 1) + 1,
    localparam int STEP_W   = $clog2(MAX_STEP + 1) + 1,
    localparam int FREQ_W   = FREQ_FRAC + STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic [LANES-1:0]  early,
    input  logic [LANES-1:0]  late,
    input  logic [KP_W-1:0]   kp_shift,
    input  logic [KI_W-1:0]   ki_shift,
    input  logic [K_W-1:0]    tx_shift,
    output logic [CODE_W-1:0] rx_code,
    output logic [CODE_W-1:0] tx_code,
    output logic [FREQ_W-1:0] freq_word
);
    typedef struct packed {
        logic [CODE_W-1:0] rx;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic signed [NET_W-1:0]  net;
    logic signed [STEP_W-1:0] step;
    logic signed [FREQ_W-1:0] freq;

    cdr_vote_sum #(.LANES(LANES), .NET_W(NET_W)) u_votes (
        .early_i (early),
        .late_i  (late),
        .net_o   (net)
    );

    cdr_loop_filter #(
        .NET_W(NET_W), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP),
        .FREQ_FRAC(FREQ_FRAC), .FREQ_W(FREQ_W), .KP_W(KP_W), .KI_W(KI_W)
    ) u_loop (
        .clk    (clk),
        .rst    (rst),
        .hold_i (freeze),
        .net_i  (net),
        .kp_i   (kp_shift),
        .ki_i   (ki_shift),
        .step_o (step),
        .freq_o (freq)
    );

    cdr_tx_smoother #(
        .STEP_W(STEP_W), .CODE_W(CODE_W), .TX_FRAC(TX_FRAC), .K_W(K_W)
    ) u_tx (
        .clk    (clk),
        .rst    (rst),
        .hold_i (freeze),
        .step_i (step),
        .k_i    (tx_shift),
        .code_o (tx_code)
    );

    always_comb begin
        st_d = st_q;
        if (!freeze) begin
            st_d.rx = st_q.rx + CODE_W'(step);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_code   = st_q.rx;
    assign freq_word = freq;

    // R2: matching early and late words carry no net vote
    assert_balanced_votes_R2: assert property (@(posedge clk) disable iff (rst)
        (early == late) |-> (net == '0));

    // R4: the receive code never moves more than the step limit per cycle
    assert_step_limit_R4: assert property (@(posedge clk) disable iff (rst)
        ((CODE_W'(st_q.rx - $past(st_q.rx)) <= CODE_W'(MAX_STEP)) ||
         (CODE_W'($past(st_q.rx) - st_q.rx) <= CODE_W'(MAX_STEP))));

    // R11: frozen loop keeps every visible code and the frequency register
    assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ($stable(rx_code) && $stable(tx_code) && $stable(freq_word)));
endmodule

// File: tb/test_cdr_phase_rotator.sv
`timescale 1ns/1ps
module test_cdr_phase_rotator;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       freeze = 1'b0;
    logic [3:0] early = '0;
    logic [3:0] late = '0;
    logic [1:0] kp_shift = '0;
    logic [2:0] ki_shift = 3'd7;
    logic [2:0] tx_shift = '0;
    logic [4:0] rx_code, tx_code;
    logic [11:0] freq_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int m_rx, m_f, m_y, m_p;

    always #2 clk = ~clk;

    cdr_phase_rotator i_cdr_phase_rotator (
        .clk(clk), .rst(rst), .freeze(freeze), .early(early), .late(late),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .tx_shift(tx_shift),
        .rx_code(rx_code), .tx_code(tx_code), .freq_word(freq_word)
    );

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int net_of(input logic [3:0] e, input logic [3:0] l);
        int n = 0;
        for (int i = 0; i < 4; i++) begin
            if (e[i] && !l[i]) n++;
            if (l[i] && !e[i]) n--;
        end
        return n;
    endfunction

    task automatic model_update(input logic [3:0] e, input logic [3:0] l);
        int n, p, fi, st, inc;
        if (freeze) return;
        n  = net_of(e, l);
        p  = n >>> kp_shift;
        fi = m_f >>> 8;
        st = p + fi;
        if (st > 2) st = 2;
        if (st < -2) st = -2;
        inc = (n * 256) >>> ki_shift;
        m_f = m_f + inc;
        if (m_f > 512) m_f = 512;
        if (m_f < -512) m_f = -512;
        m_rx = (m_rx + st) & 31;
        m_y = m_y + (((st * 256) - m_y) >>> tx_shift);
        m_p = (m_p + m_y) & 8191;
    endtask

    task automatic cyc(input logic [3:0] e, input logic [3:0] l, input string tag);
        early = e;
        late  = l;
        @(posedge clk);
        model_update(e, l);
        @(negedge clk);
        check_eq(tag, "rx_code", int'(rx_code), m_rx);
        check_eq(tag, "tx_code", int'(tx_code), m_p >> 8);
        check_eq(tag, "freq_word", int'($signed(freq_word)), m_f);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        early = '0;
        late = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_rx = 0; m_f = 0; m_y = 0; m_p = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check_eq("R1", "rx_code after reset", int'(rx_code), 0);
        check_eq("R1", "tx_code after reset", int'(tx_code), 0);
        check_eq("R1", "freq_word after reset", int'($signed(freq_word)), 0);
    endtask

    task automatic t_votes();
        do_reset();
        kp_shift = 2'd0; ki_shift = 3'd7; tx_shift = 3'd0;
        cyc(4'b0000, 4'b0000, "R2");
        cyc(4'b1111, 4'b1111, "R2");
        check_eq("R2", "both-set lanes rx", int'(rx_code), 0);
        cyc(4'b0011, 4'b0100, "R2");
        check_eq("R2", "net +1 rx", int'(rx_code), 1);
        check_eq("R2", "net +1 freq", int'($signed(freq_word)), 2);
        cyc(4'b0000, 4'b0110, "R2");
        check_eq("R2", "net -2 rx", int'(rx_code), 31);
    endtask

    task automatic t_prop();
        do_reset();
        kp_shift = 2'd2; ki_shift = 3'd7;
        cyc(4'b1110, 4'b0000, "R3");
        check_eq("R3", "3>>>2 rx", int'(rx_code), 0);
        cyc(4'b0000, 4'b0001, "R3");
        check_eq("R3", "-1>>>2 floors rx", int'(rx_code), 31);
    endtask

    task automatic t_sat();
        do_reset();
        kp_shift = 2'd0; ki_shift = 3'd7;
        cyc(4'b1111, 4'b0000, "R4");
        check_eq("R4", "clamp +2 rx", int'(rx_code), 2);
        cyc(4'b0000, 4'b1111, "R4");
        check_eq("R4", "clamp -2 rx", int'(rx_code), 0);
    endtask

    task automatic t_wrap();
        do_reset();
        kp_shift = 2'd0; ki_shift = 3'd7; tx_shift = 3'd2;
        for (int i = 0; i < 20; i++) cyc(4'b1111, 4'b0000, "R5_R12 up");
        for (int i = 0; i < 40; i++) cyc(4'b0000, 4'b1111, "R5_R12 down");
    endtask

    task automatic t_integral();
        do_reset();
        kp_shift = 2'd3; ki_shift = 3'd0; tx_shift = 3'd0;
        cyc(4'b0001, 4'b0000, "R6");
        check_eq("R6", "freq +256", int'($signed(freq_word)), 256);
        check_eq("R8", "old freq used rx", int'(rx_code), 0);
        cyc(4'b0000, 4'b0000, "R6");
        check_eq("R6", "idle keeps freq", int'($signed(freq_word)), 256);
        check_eq("R8", "integer part drives rx", int'(rx_code), 1);
        cyc(4'b0000, 4'b0001, "R8");
        ki_shift = 3'd2;
        cyc(4'b0000, 4'b0001, "R6");
        check_eq("R6", "freq -64", int'($signed(freq_word)), -64);
        cyc(4'b0000, 4'b0000, "R8");
        check_eq("R8", "floor of -64 rx", int'(rx_code), 31);
    endtask

    task automatic t_freq_sat();
        do_reset();
        kp_shift = 2'd3; ki_shift = 3'd0;
        for (int i = 0; i < 5; i++) begin
            cyc(4'b1111, 4'b0000, "R7");
            check_eq("R7", "freq high limit", int'($signed(freq_word)), 512);
        end
        for (int i = 0; i < 4; i++) cyc(4'b0000, 4'b1111, "R7");
        check_eq("R7", "freq low limit", int'($signed(freq_word)), -512);
    endtask

    task automatic t_tx_k0();
        do_reset();
        kp_shift = 2'd1; ki_shift = 3'd3; tx_shift = 3'd0;
        for (int i = 0; i < 30; i++) begin
            cyc(4'(i * 7 + 3), 4'(i * 5), "R9");
            check_eq("R9", "tx equals rx", int'(tx_code), int'(rx_code));
        end
    endtask

    task automatic t_tx_smooth();
        do_reset();
        kp_shift = 2'd0; ki_shift = 3'd7; tx_shift = 3'd3;
        cyc(4'b1111, 4'b0000, "R10");
        check_eq("R10", "first smoothed tx", int'(tx_code), 0);
        for (int i = 0; i < 16; i++) cyc(4'b1111, 4'b0000, "R10");
        for (int i = 0; i < 12; i++) cyc(4'b0000, 4'b0000, "R10");
        tx_shift = 3'd7;
        for (int i = 0; i < 10; i++) cyc(4'b0000, 4'b1111, "R10_R12");
    endtask

    task automatic t_freeze();
        int rx0, tx0, f0;
        do_reset();
        kp_shift = 2'd0; ki_shift = 3'd4; tx_shift = 3'd2;
        for (int i = 0; i < 5; i++) cyc(4'b1111, 4'b0000, "R11 pre");
        rx0 = int'(rx_code); tx0 = int'(tx_code); f0 = int'($signed(freq_word));
        freeze = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cyc(4'b0000, 4'b1111, "R11");
            check_eq("R11", "rx held", int'(rx_code), rx0);
            check_eq("R11", "tx held", int'(tx_code), tx0);
            check_eq("R11", "freq held", int'($signed(freq_word)), f0);
        end
        freeze = 1'b0;
        for (int i = 0; i < 6; i++) cyc(4'b0000, 4'b0000, "R11 post");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_votes();
        t_prop();
        t_sat();
        t_wrap();
        t_integral();
        t_freq_sat();
        t_tx_k0();
        t_tx_smooth();
        t_freeze();
        finish_run();
    end
endmodule